// File: doc/BRIEF.md
# Virtual-Channel Router Input Controller

This block sits at the receiving end of one tile link of an on-chip router. Each flit arrives as a wide data word plus a 38-bit control word. The controller decodes the control word and picks the virtual channel the flit belongs to. It keeps a short FIFO and a small state machine for each of eight virtual channels, and it tells the upstream sender, per channel, whether another flit fits.

On a head flit the controller removes the current hop from the source route. That hop becomes the output port the packet asks for. For every channel whose packet waits at the front of its FIFO, the controller raises a request for an output virtual channel. Once the request is granted, the channel's flits are offered to the switch until the tail leaves. Channel 0 carries static streaming traffic and skips the request/grant step.

Top module: `vc_input_ctrl`

## Requirements
- R1: Control word layout: bits [1:0] flit kind (00 idle, 01 head, 10 body, 11 tail), [5:2] size code (0 to 8), [13:6] channel mask, [29:14] source route, [37:30] per-channel ready. On input the ready field is ignored. On `outCtrl` the ready field is always zero.
- R2: A flit is stored in the channel given by the lowest set bit of its mask. A flit whose mask is zero is discarded.
- R3: Idle-kind flits are never stored in any channel.
- R4: Each channel holds up to 4 flits in arrival order. `readyUp[v]` is high exactly when channel v holds fewer than 4 flits. A flit that arrives at a full channel is dropped.
- R5: When a head flit is stored, its route bits [1:0] become the requested port on `reqPort[2v+1:2v]`, and the route it carries onward is the incoming route shifted right by 2. Body and tail flits keep their route unchanged.
- R6: On a dynamic channel (1 to 7) whose state is idle and whose front flit is a head, `reqVc[v]` goes high after the second rising edge counting the edge that stored the head. No output flit is offered on that channel while it requests.
- R7: If `grantVc[v]` is high at a rising edge while `reqVc[v]` is high, the channel becomes active at that edge. An active channel drives `outValid[v]` high whenever it holds a flit.
- R8: Channel 0 never raises `reqVc`. A head at its front makes it active at the next edge without a grant.
- R9: A flit is removed at a rising edge where `readEn` is high and `readSel` names an active channel holding a flit. `outData` and `outCtrl` always show the front flit of the channel that `readSel` names. Removing a tail returns the channel to idle.
- R10: A body or tail flit that reaches the front of an idle channel is dropped at the next edge.
- R11: The size code and the mask pass to `outCtrl` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A flit is present on the link |
| inData | input | DATA_W | Flit payload |
| inCtrl | input | 38 | Flit control word |
| readyUp | output | 8 | Per-channel space available, sent upstream |
| reqVc | output | 8 | Per-channel output-VC request |
| reqPort | output | 16 | Requested output port, 2 bits per channel |
| grantVc | input | 8 | Per-channel output-VC grant |
| readEn | input | 1 | Switch takes the selected channel's front flit |
| readSel | input | 3 | Channel index for reading |
| outValid | output | 8 | Per-channel flit offered to the switch |
| outData | output | DATA_W | Front payload of the selected channel |
| outCtrl | output | 38 | Front control word of the selected channel, route stripped |

## Verification
The hardest state to reach from the ports is a granted channel that is still active but has run out of flits. Its FIFO must first fill to 4 while the channel waits for a grant. A fifth flit is then sent, which must be dropped. After the grant, all 4 entries are read, and only then does the tail arrive. The bench builds that sequence on one channel and checks that the late tail is offered at once, without a new request, and that the dropped flit never shows up. The bench also sweeps every channel with its own route and size values. The expected port and stripped route are computed by arithmetic in the bench.

// File: rtl/vcic_pkg.sv
package vcic_pkg;
  localparam int NUM_VC   = 8;
  localparam int VC_IDX_W = $clog2(NUM_VC);
  localparam int PORT_W   = 2;
  localparam int ROUTE_W  = 16;
  localparam int CTRL_W   = 38;

  typedef enum logic [1:0] {
    FT_IDLE = 2'b00,
    FT_HEAD = 2'b01,
    FT_BODY = 2'b10,
    FT_TAIL = 2'b11
  } flitKind_e;

  // Fixed link layout: the upstream neighbour encodes these positions.
  typedef struct packed {
    logic [NUM_VC-1:0]  ready;
    logic [ROUTE_W-1:0] route;
    logic [NUM_VC-1:0]  mask;
    logic [3:0]         size;
    flitKind_e          kind;
  } ctrlWord_t;

  typedef enum logic [1:0] {
    VS_IDLE   = 2'd0,
    VS_WAIT   = 2'd1,
    VS_ACTIVE = 2'd2
  } vcState_e;

  typedef struct packed {
    logic [NUM_VC-1:0] pop;
  } ctlStrobe_t;

  function automatic logic [VC_IDX_W-1:0] lowestVc(input logic [NUM_VC-1:0] m);
    logic [VC_IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_VC - 1; i >= 0; i--) begin
      if (m[i]) r = VC_IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/vcic_datapath.sv
module vcic_datapath
  import vcic_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [DATA_W-1:0]          inData,
  input  ctrlWord_t                  inCtrlS,
  input  ctlStrobe_t                 strobe,
  input  logic [VC_IDX_W-1:0]        readSel,
  output logic [NUM_VC-1:0]          readyUp,
  output logic [NUM_VC-1:0]          notEmpty,
  output flitKind_e [NUM_VC-1:0]     frontKind,
  output logic [NUM_VC*PORT_W-1:0]   frontPort,
  output logic [DATA_W-1:0]          outData,
  output logic [CTRL_W-1:0]          outCtrl
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [VC_IDX_W-1:0] wrVc;
  logic                accept;
  ctrlWord_t           storeCtrl;
  logic [PORT_W-1:0]   storePort;
  logic [NUM_VC-1:0]   isFull;

  logic [DATA_W-1:0] frontData [NUM_VC];
  ctrlWord_t         frontCtrl [NUM_VC];

  assign wrVc   = lowestVc(inCtrlS.mask);
  assign accept = inValid && (inCtrlS.kind != FT_IDLE) && (|inCtrlS.mask) && !isFull[wrVc];

  always_comb begin
    storeCtrl       = inCtrlS;
    storeCtrl.ready = '0;
    storePort       = inCtrlS.route[PORT_W-1:0];
    if (inCtrlS.kind == FT_HEAD) storeCtrl.route = inCtrlS.route >> PORT_W;
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [DATA_W-1:0] dMem [DEPTH];
    ctrlWord_t         cMem [DEPTH];
    logic [PORT_W-1:0] pMem [DEPTH];
    logic [PTR_W-1:0]  wrPtr, rdPtr;
    logic [CNT_W-1:0]  cnt;
    logic              wrHere, popHere;

    assign wrHere  = accept && (wrVc == VC_IDX_W'(v));
    assign popHere = strobe.pop[v];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        cnt   <= '0;
      end else begin
        if (wrHere) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        if (popHere) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        cnt <= cnt + CNT_W'(wrHere) - CNT_W'(popHere);
      end
    end

    always_ff @(posedge clk) begin
      if (wrHere) begin
        dMem[wrPtr] <= inData;
        cMem[wrPtr] <= storeCtrl;
        pMem[wrPtr] <= storePort;
      end
    end

    assign isFull[v]    = (cnt == CNT_W'(DEPTH));
    assign readyUp[v]   = !isFull[v];
    assign notEmpty[v]  = (cnt != '0);
    assign frontData[v] = dMem[rdPtr];
    assign frontCtrl[v] = cMem[rdPtr];
    assign frontKind[v] = cMem[rdPtr].kind;
    assign frontPort[v*PORT_W +: PORT_W] = pMem[rdPtr];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      cnt <= CNT_W'(DEPTH)) else $error("buffer overflow"); // R4
    AST_POP_HAS_FLIT: assert property (@(posedge clk) disable iff (!rstN)
      popHere |-> cnt != '0) else $error("pop of empty buffer"); // R9
    AST_IDLE_NOT_STORED: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && inCtrlS.kind == FT_IDLE && !popHere) |=> $stable(cnt))
      else $error("idle flit stored"); // R3
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rstN)
      (cnt == CNT_W'(DEPTH) && !popHere) |=> cnt == CNT_W'(DEPTH))
      else $error("full buffer changed"); // R4
  end

  assign outData = frontData[readSel];
  assign outCtrl = frontCtrl[readSel];
endmodule

// File: rtl/vcic_control.sv
module vcic_control
  import vcic_pkg::*;
#(
  parameter int STATIC_VC = 0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_VC-1:0]      notEmpty,
  input  flitKind_e [NUM_VC-1:0] frontKind,
  input  logic [NUM_VC-1:0]      grantVc,
  input  logic                   readEn,
  input  logic [VC_IDX_W-1:0]    readSel,
  output ctlStrobe_t             strobe,
  output logic [NUM_VC-1:0]      reqVc,
  output logic [NUM_VC-1:0]      outValid
);
  for (genvar v = 0; v < NUM_VC; v++) begin : g_fsm
    localparam bit IS_STATIC = (v == STATIC_VC);
    vcState_e st, stNext;
    logic readHit, orphan;

    assign readHit = (st == VS_ACTIVE) && notEmpty[v] && readEn && (readSel == VC_IDX_W'(v));
    assign orphan  = (st == VS_IDLE) && notEmpty[v] && (frontKind[v] != FT_HEAD);

    assign strobe.pop[v] = readHit || orphan;
    assign reqVc[v]      = (st == VS_WAIT);
    assign outValid[v]   = (st == VS_ACTIVE) && notEmpty[v];

    always_comb begin
      stNext = st;
      unique case (st)
        VS_IDLE:   if (notEmpty[v] && frontKind[v] == FT_HEAD)
                     stNext = IS_STATIC ? VS_ACTIVE : VS_WAIT;
        VS_WAIT:   if (grantVc[v]) stNext = VS_ACTIVE;
        VS_ACTIVE: if (readHit && frontKind[v] == FT_TAIL) stNext = VS_IDLE;
        default:   stNext = VS_IDLE;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) st <= VS_IDLE;
      else       st <= stNext;
    end

    AST_REQ_HAS_HEAD: assert property (@(posedge clk) disable iff (!rstN)
      reqVc[v] |-> (notEmpty[v] && frontKind[v] == FT_HEAD))
      else $error("request without head"); // R6
    AST_GRANT_ACTIVATES: assert property (@(posedge clk) disable iff (!rstN)
      (reqVc[v] && grantVc[v]) |=> outValid[v])
      else $error("grant not honoured"); // R7
    AST_TAIL_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[v] && readEn && readSel == VC_IDX_W'(v) && frontKind[v] == FT_TAIL)
        |=> (!outValid[v] && !reqVc[v]))
      else $error("tail did not close channel"); // R9
    if (IS_STATIC) begin : g_static
      AST_STATIC_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
        (st == VS_IDLE && notEmpty[v] && frontKind[v] == FT_HEAD) |=> (outValid[v] && !reqVc[v]))
        else $error("static channel arbitrated"); // R8
    end
  end
endmodule

// File: rtl/vc_input_ctrl.sv
module vc_input_ctrl
  import vcic_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int DEPTH     = 4,
  parameter int STATIC_VC = 0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [DATA_W-1:0]         inData,
  input  logic [CTRL_W-1:0]         inCtrl,
  output logic [NUM_VC-1:0]         readyUp,
  output logic [NUM_VC-1:0]         reqVc,
  output logic [NUM_VC*PORT_W-1:0]  reqPort,
  input  logic [NUM_VC-1:0]         grantVc,
  input  logic                      readEn,
  input  logic [VC_IDX_W-1:0]       readSel,
  output logic [NUM_VC-1:0]         outValid,
  output logic [DATA_W-1:0]         outData,
  output logic [CTRL_W-1:0]         outCtrl
);
  ctrlWord_t             inCtrlS;
  ctlStrobe_t            strobe;
  logic [NUM_VC-1:0]     notEmpty;
  flitKind_e [NUM_VC-1:0] frontKind;

  assign inCtrlS = inCtrl;

  vcic_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inCtrlS(inCtrlS),
    .strobe(strobe), .readSel(readSel), .readyUp(readyUp), .notEmpty(notEmpty),
    .frontKind(frontKind), .frontPort(reqPort), .outData(outData), .outCtrl(outCtrl)
  );

  vcic_control #(.STATIC_VC(STATIC_VC)) u_ctl (
    .clk(clk), .rstN(rstN), .notEmpty(notEmpty), .frontKind(frontKind),
    .grantVc(grantVc), .readEn(readEn), .readSel(readSel), .strobe(strobe),
    .reqVc(reqVc), .outValid(outValid)
  );
endmodule

// File: tb/vc_input_ctrl_bench.sv
`timescale 1ns/1ps
module vc_input_ctrl_bench;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic [37:0] inCtrl = '0;
  logic [7:0] readyUp, reqVc, grantVc = '0, outValid;
  logic [15:0] reqPort;
  logic readEn = 1'b0;
  logic [2:0] readSel = '0;
  logic [DW-1:0] outData;
  logic [37:0] outCtrl;

  int nChecks = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  vc_input_ctrl u_vc_input_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inCtrl(inCtrl),
    .readyUp(readyUp), .reqVc(reqVc), .reqPort(reqPort), .grantVc(grantVc),
    .readEn(readEn), .readSel(readSel), .outValid(outValid), .outData(outData),
    .outCtrl(outCtrl)
  );

  localparam logic [1:0] K_IDLE = 2'b00, K_HEAD = 2'b01, K_BODY = 2'b10, K_TAIL = 2'b11;

  function automatic logic [37:0] mkCtrl(logic [1:0] k, logic [3:0] sz, logic [7:0] m, logic [15:0] rt);
    return {8'hA5, rt, m, sz, k};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sendFlit(logic [1:0] k, logic [3:0] sz, logic [7:0] m, logic [15:0] rt, logic [DW-1:0] d);
    inValid = 1'b1; inCtrl = mkCtrl(k, sz, m, rt); inData = d;
    @(negedge clk);
    inValid = 1'b0; inCtrl = '0;
  endtask

  task automatic grant(int v);
    grantVc = 8'(1 << v);
    @(negedge clk);
    grantVc = '0;
  endtask

  // expected outCtrl: ready zero, route stripped on heads
  task automatic readFlit(string tag, int v, logic [1:0] k, logic [3:0] sz, logic [7:0] m,
                          logic [15:0] rt, logic [DW-1:0] d);
    logic [15:0] expRt;
    expRt = (k == K_HEAD) ? (rt >> 2) : rt;
    readSel = 3'(v);
    #0;
    chk({tag, " valid"}, 64'(outValid[v]), 64'd1);
    chk({tag, " data"}, outData, d);
    chk({tag, " ctrl"}, 64'(outCtrl), 64'({8'h00, expRt, m, sz, k}));
    readEn = 1'b1;
    @(negedge clk);
    readEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R4 reset state
    chk("R4 reset readyUp", 64'(readyUp), 64'hFF);
    chk("R6 reset reqVc", 64'(reqVc), 64'h0);
    chk("R7 reset outValid", 64'(outValid), 64'h0);

    // Sweep every channel: R1 R2 R5 R6 R7 R8 R9 R11
    for (int v = 0; v < 8; v++) begin
      logic [15:0] rt;
      logic [7:0] m;
      logic [3:0] sz;
      rt = 16'h1234 + 16'(v) * 16'h0F0F;
      m  = 8'(1 << v);
      sz = 4'(v + 1);
      sendFlit(K_HEAD, sz, m, rt, 64'h1000 + 64'(v));
      sendFlit(K_BODY, sz, m, rt, 64'h2000 + 64'(v));
      sendFlit(K_TAIL, sz, m, rt, 64'h3000 + 64'(v));
      if (v == 0) begin
        chk("R8 static no request", 64'(reqVc), 64'h0);
        chk("R8 static active", 64'(outValid), 64'h1);
      end else begin
        chk("R6 request raised", 64'(reqVc), 64'(m));
        chk("R6 no offer while waiting", 64'(outValid), 64'h0);
        chk("R5 requested port", 64'(reqPort[2*v +: 2]), 64'(rt[1:0]));
        grant(v);
        chk("R7 request drops on grant", 64'(reqVc), 64'h0);
      end
      readFlit("R5 head", v, K_HEAD, sz, m, rt, 64'h1000 + 64'(v));
      readFlit("R11 body", v, K_BODY, sz, m, rt, 64'h2000 + 64'(v));
      readFlit("R9 tail", v, K_TAIL, sz, m, rt, 64'h3000 + 64'(v));
      chk("R9 channel back to idle", 64'({reqVc, outValid}), 64'h0);
    end

    // Size code 8 passes unchanged on static channel (R11)
    sendFlit(K_HEAD, 4'd8, 8'h01, 16'hFFFF, 64'hAB);
    sendFlit(K_TAIL, 4'd8, 8'h01, 16'hFFFF, 64'hCD);
    readFlit("R11 size8 head", 0, K_HEAD, 4'd8, 8'h01, 16'hFFFF, 64'hAB);
    readFlit("R11 size8 tail", 0, K_TAIL, 4'd8, 8'h01, 16'hFFFF, 64'hCD);

    // Fill channel 3 while waiting; fifth flit dropped (R4)
    sendFlit(K_HEAD, 4'd2, 8'h08, 16'h00C6, 64'h40);
    for (int k = 1; k < 4; k++) sendFlit(K_BODY, 4'd2, 8'h08, 16'h00C6, 64'h40 + 64'(k));
    chk("R4 full not ready", 64'(readyUp), 64'hF7);
    sendFlit(K_BODY, 4'd2, 8'h08, 16'h00C6, 64'hDEAD);
    chk("R4 still full", 64'(readyUp), 64'hF7);
    chk("R5 port on full channel", 64'(reqPort[7:6]), 64'd2);
    grant(3);
    readFlit("R4 fifo head", 3, K_HEAD, 4'd2, 8'h08, 16'h00C6, 64'h40);
    for (int k = 1; k < 4; k++) readFlit("R4 fifo order", 3, K_BODY, 4'd2, 8'h08, 16'h00C6, 64'h40 + 64'(k));
    chk("R7 empty active no offer", 64'({reqVc, outValid}), 64'h0);
    sendFlit(K_TAIL, 4'd2, 8'h08, 16'h00C6, 64'h4F);
    chk("R7 late tail offered", 64'(outValid), 64'h08);
    readFlit("R4 dropped flit absent", 3, K_TAIL, 4'd2, 8'h08, 16'h00C6, 64'h4F);

    // Idle-kind and zero-mask flits discarded (R3, R2)
    sendFlit(K_IDLE, 4'd0, 8'h20, 16'h0003, 64'hBAD0);
    sendFlit(K_HEAD, 4'd0, 8'h00, 16'h0003, 64'hBAD1);
    @(negedge clk); @(negedge clk);
    chk("R3 idle not stored", 64'({readyUp, reqVc, outValid}), 64'hFF0000);
    // multi-bit mask picks lowest bit: VC5 (R2)
    sendFlit(K_HEAD, 4'd1, 8'h60, 16'h0003, 64'h55);
    @(negedge clk);
    chk("R2 lowest mask bit", 64'(reqVc), 64'h20);
    grant(5);
    readFlit("R3 front is head not idle", 5, K_HEAD, 4'd1, 8'h60, 16'h0003, 64'h55);
    sendFlit(K_TAIL, 4'd1, 8'h20, 16'h0003, 64'h56);
    readFlit("R2 tail", 5, K_TAIL, 4'd1, 8'h20, 16'h0003, 64'h56);

    // Orphan body dropped on idle channel 6 (R10)
    sendFlit(K_BODY, 4'd3, 8'h40, 16'h0001, 64'h99);
    @(negedge clk); @(negedge clk);
    chk("R10 orphan dropped", 64'({readyUp, reqVc, outValid}), 64'hFF0000);
    // Two channels waiting at once, grant only one (R6, R7)
    sendFlit(K_HEAD, 4'd3, 8'h40, 16'h0001, 64'h61);
    sendFlit(K_HEAD, 4'd3, 8'h02, 16'h0002, 64'h62);
    @(negedge clk);
    chk("R6 two requests", 64'(reqVc), 64'h42);
    chk("R6 ports", 64'({reqPort[13:12], reqPort[3:2]}), 64'b0110);
    grant(6);
    chk("R7 ungranted still waits", 64'({reqVc, outValid}), 64'h0240);
    readFlit("R10 head after orphan", 6, K_HEAD, 4'd3, 8'h40, 16'h0001, 64'h61);
    sendFlit(K_TAIL, 4'd3, 8'h40, 16'h0001, 64'h63);
    readFlit("R9 tail vc6", 6, K_TAIL, 4'd3, 8'h40, 16'h0001, 64'h63);
    grant(1);
    readFlit("R7 late grant head", 1, K_HEAD, 4'd3, 8'h02, 16'h0002, 64'h62);
    sendFlit(K_TAIL, 4'd3, 8'h02, 16'h0002, 64'h64);
    readFlit("R9 tail vc1", 1, K_TAIL, 4'd3, 8'h02, 16'h0002, 64'h64);
    chk("R9 all idle", 64'({readyUp, reqVc, outValid}), 64'hFF0000);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule